// File: doc/BRIEF.md
# Floppy Sector Sequencer with End-of-Track Handling

This block tracks the cylinder, head and sector position of a floppy disk controller data command while the command runs. A command is loaded with its opcode, drive number, multi-track flag, sectors per track, highest cylinder and start position. After that, every sector-done pulse advances the position by one sector. The head advances to the second side when multi-track is enabled. At the end of the disk the cylinder saturates at the highest cylinder instead of running past it.

The end-of-track flag in the second status byte is raised one sector early, when the sector just reached is the last one of the final side. If another sector-done pulse comes while the flag is already set, the command ends as an abnormal termination. A pulse together with terminal count is a normal finish. When a normal finish on a read or write data command happens with the flag set, one extra step is taken before the result is given, and the head bit of the first status byte is updated to match.

At the end the block drops the DMA request, raises the interrupt, and hands out a seven-byte result. One byte comes out per data-port read. After the last byte it returns to idle.

Top module: `sector_seq`

## Requirements
- R1: After reset, st0, st1 and st2 are 0x00, mrq is 1, and dio, irq, res_start and dma_drop are 0.
- R2: A sector step adds one to the sector. Past sectors-per-track the sector wraps to 1. With multi-track set and head 0, the head moves to 1. Otherwise the head goes to 0 and the cylinder increments.
- R3: A cylinder increment from a cylinder at or above the highest cylinder leaves the cylinder at the highest cylinder.
- R4: After a step, st1 bit 7 (end of track) is set when the new head equals the multi-track flag and the new sector equals sectors-per-track.
- R5: A sector-done pulse while st1 bit 7 is set does not step. It writes st0 = 0x40 | head<<2 | drive, pulses dma_drop one cycle later, and ends the command.
- R6: A sector-done pulse with term_count (st1 bit 7 clear) steps first. It then writes st0 = head<<2 | drive (bits 1:0 drive, bit 2 head, bits 7:6 zero), clears st2, keeps st1, pulses dma_drop and ends the command.
- R7: For opcodes 0x46, 0x66, 0xC6, 0xE6, 0x45 and 0xC5, if st0 bits 7:6 are 00 and st1 bit 7 is set at the end, st1 bit 7 is cleared, one more step is taken, and st0 bit 2 is rewritten with the new head.
- R8: Any other opcode, for example 0x4A or 0x4D, gets no extra step and keeps st1 bit 7 in the result.
- R9: res_start and irq rise two cycles after the ending pulse, one cycle after dma_drop. The result bytes are, in order: st0, st1, st2, cylinder, head, sector, 0x02.
- R10: Each data_rd advances the result by one byte. irq clears on the first read. dio stays 1 until the seventh byte has been read.
- R11: After the seventh read, dio is 0, mrq is 1, st1 and st2 are 0x00, and st0 is unchanged.
- R12: cmd_load is ignored unless the block is idle. sector_done is ignored unless a command is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_load | input | 1 | Start a command (idle only) |
| cmd_op | input | 8 | Command opcode |
| drv_sel | input | 2 | Drive number |
| mt_en | input | 1 | Multi-track enable |
| spt | input | 8 | Sectors per track |
| max_cyl | input | 8 | Highest cylinder |
| start_cyl | input | 8 | Start cylinder |
| start_head | input | 1 | Start head |
| start_sec | input | 8 | Start sector |
| sector_done | input | 1 | One sector transferred |
| term_count | input | 1 | Terminal count with sector_done |
| data_rd | input | 1 | Data-port read strobe |
| st0 | output | 8 | Status byte 0 |
| st1 | output | 8 | Status byte 1 |
| st2 | output | 8 | Status byte 2 |
| cyl_o | output | 8 | Current cylinder |
| head_o | output | 1 | Current head |
| sec_o | output | 8 | Current sector |
| dma_drop | output | 1 | Pulse: drop DMA request |
| res_start | output | 1 | Pulse: result phase begins |
| irq | output | 1 | Interrupt request |
| mrq | output | 1 | Data register ready |
| dio | output | 1 | Result bytes pending toward the host |
| res_data | output | 8 | Current result byte |

## Verification
Position and status updates appear at the first clock edge after a sector-done pulse. dma_drop follows at that same edge, and res_start and irq follow one edge later, when the extra step for data commands also lands. The bench drives every input on the falling edge and samples on the next falling edge. It checks dma_drop right after the ending pulse and res_start one cycle after that. Each result byte is compared before the read strobe that pops it, and dio and the cleared status bytes are checked on the falling edge after the seventh read.

// File: rtl/sector_seq_pkg.sv
package sector_seq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_XFER, SQ_FIN, SQ_RES} sq_state_t;

  localparam int         RES_LEN    = 7;
  localparam logic [7:0] SIZE_CODE  = 8'h02;
  localparam int         EOT_BIT    = 7;
  localparam logic [1:0] TERM_OK    = 2'b00;
  localparam logic [1:0] TERM_ABORT = 2'b01;

  // read/write data commands that take the extra step at end of track
  function automatic logic is_xfer_op(input logic [7:0] op);
    case (op)
      8'h46, 8'h66, 8'hC6, 8'hE6, 8'h45, 8'hC5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] make_st0(input logic [1:0] code, input logic hd,
                                          input logic [1:0] drv);
    return {code, 3'b000, hd, drv};
  endfunction
endpackage

// File: rtl/seq_chs_step.sv
module seq_chs_step #(
  parameter int CYL_W = 8,
  parameter int SEC_W = 8
) (
  input  logic [CYL_W-1:0] cyl,
  input  logic             head,
  input  logic [SEC_W-1:0] sec,
  input  logic             mt,
  input  logic [SEC_W-1:0] spt,
  input  logic [CYL_W-1:0] max_cyl,
  output logic [CYL_W-1:0] n_cyl,
  output logic             n_head,
  output logic [SEC_W-1:0] n_sec,
  output logic             n_eot
);
  function automatic logic past_end(input logic [SEC_W-1:0] s, input logic [SEC_W-1:0] lim);
    return s >= lim;
  endfunction

  function automatic logic [CYL_W-1:0] clamp_inc(input logic [CYL_W-1:0] c,
                                                 input logic [CYL_W-1:0] lim);
    return (c >= lim) ? lim : c + 1'b1;
  endfunction

  logic wrap;
  logic side_flip;

  always_comb begin
    wrap      = past_end(sec, spt);
    side_flip = wrap && mt && !head;
    n_sec     = wrap ? SEC_W'(1) : sec + 1'b1;
    n_head    = wrap ? side_flip : head;
    n_cyl     = (wrap && !side_flip) ? clamp_inc(cyl, max_cyl) : cyl;
    n_eot     = (mt == n_head) && (n_sec == spt);
  end
endmodule

// File: rtl/seq_result_port.sv
module seq_result_port #(
  parameter int RES_LEN = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    open,
  input  logic                    data_rd,
  input  logic [RES_LEN-1:0][7:0] bytes_in,
  output logic [7:0]              res_data,
  output logic                    last_pop
);
  localparam int IDX_W = (RES_LEN > 1) ? $clog2(RES_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RES_LEN - 1);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) idx <= '0;
    else if (start) idx <= '0;
    else if (open && data_rd && idx != LAST) idx <= idx + 1'b1;
  end

  always_comb begin
    res_data = 8'h00;
    for (int i = 0; i < RES_LEN; i++)
      if (open && idx == IDX_W'(i)) res_data = bytes_in[i];
    last_pop = open && data_rd && (idx == LAST);
  end
endmodule

// File: rtl/sector_seq.sv
module sector_seq
  import sector_seq_pkg::*;
#(
  parameter int CYL_W = 8,
  parameter int SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_load,
  input  logic [7:0]       cmd_op,
  input  logic [1:0]       drv_sel,
  input  logic             mt_en,
  input  logic [SEC_W-1:0] spt,
  input  logic [CYL_W-1:0] max_cyl,
  input  logic [CYL_W-1:0] start_cyl,
  input  logic             start_head,
  input  logic [SEC_W-1:0] start_sec,
  input  logic             sector_done,
  input  logic             term_count,
  input  logic             data_rd,
  output logic [7:0]       st0,
  output logic [7:0]       st1,
  output logic [7:0]       st2,
  output logic [CYL_W-1:0] cyl_o,
  output logic             head_o,
  output logic [SEC_W-1:0] sec_o,
  output logic             dma_drop,
  output logic             res_start,
  output logic             irq,
  output logic             mrq,
  output logic             dio,
  output logic [7:0]       res_data
);
  sq_state_t        state;
  logic [7:0]       op_q;
  logic [1:0]       drv_q;
  logic             mt_q;
  logic [SEC_W-1:0] spt_q;
  logic [CYL_W-1:0] max_cyl_q;
  logic [CYL_W-1:0] cyl_q;
  logic             head_q;
  logic [SEC_W-1:0] sec_q;

  logic [CYL_W-1:0] n_cyl;
  logic             n_head;
  logic [SEC_W-1:0] n_sec;
  logic             n_eot;

  // named events for the checker
  logic ev_abort;
  logic ev_step;
  logic ev_extra;
  logic ev_last;
  logic [RES_LEN-1:0][7:0] res_bytes;

  seq_chs_step #(.CYL_W(CYL_W), .SEC_W(SEC_W)) u_step (
    .cyl(cyl_q), .head(head_q), .sec(sec_q), .mt(mt_q), .spt(spt_q),
    .max_cyl(max_cyl_q), .n_cyl(n_cyl), .n_head(n_head), .n_sec(n_sec), .n_eot(n_eot)
  );

  always_comb begin
    ev_abort  = (state == SQ_XFER) && sector_done && st1[EOT_BIT];
    ev_step   = (state == SQ_XFER) && sector_done && !st1[EOT_BIT];
    ev_extra  = (state == SQ_FIN) && is_xfer_op(op_q) && (st0[7:6] == TERM_OK) && st1[EOT_BIT];
    res_bytes = {SIZE_CODE, 8'(sec_q), {7'd0, head_q}, 8'(cyl_q), st2, st1, st0};
    mrq       = (state == SQ_IDLE) || (state == SQ_RES);
    dio       = (state == SQ_RES);
  end

  seq_result_port #(.RES_LEN(RES_LEN)) u_res (
    .clk(clk), .rst_n(rst_n), .start(state == SQ_FIN), .open(state == SQ_RES),
    .data_rd(data_rd), .bytes_in(res_bytes), .res_data(res_data), .last_pop(ev_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      op_q      <= '0;
      drv_q     <= '0;
      mt_q      <= 1'b0;
      spt_q     <= '0;
      max_cyl_q <= '0;
      cyl_q     <= '0;
      head_q    <= 1'b0;
      sec_q     <= '0;
      st0       <= '0;
      st1       <= '0;
      st2       <= '0;
      dma_drop  <= 1'b0;
      res_start <= 1'b0;
      irq       <= 1'b0;
    end else begin
      dma_drop  <= 1'b0;
      res_start <= 1'b0;
      case (state)
        SQ_IDLE: if (cmd_load) begin
          op_q      <= cmd_op;
          drv_q     <= drv_sel;
          mt_q      <= mt_en;
          spt_q     <= spt;
          max_cyl_q <= max_cyl;
          cyl_q     <= start_cyl;
          head_q    <= start_head;
          sec_q     <= start_sec;
          st1       <= '0;
          st2       <= '0;
          state     <= SQ_XFER;
        end
        SQ_XFER: begin
          if (ev_abort) begin
            st0      <= make_st0(TERM_ABORT, head_q, drv_q);
            dma_drop <= 1'b1;
            state    <= SQ_FIN;
          end else if (ev_step) begin
            cyl_q  <= n_cyl;
            head_q <= n_head;
            sec_q  <= n_sec;
            if (n_eot) st1[EOT_BIT] <= 1'b1;
            if (term_count) begin
              st0      <= make_st0(TERM_OK, n_head, drv_q);
              st2      <= '0;
              dma_drop <= 1'b1;
              state    <= SQ_FIN;
            end
          end
        end
        SQ_FIN: begin
          if (ev_extra) begin
            st1[EOT_BIT] <= 1'b0;
            cyl_q        <= n_cyl;
            head_q       <= n_head;
            sec_q        <= n_sec;
            st0[2]       <= n_head;
          end
          res_start <= 1'b1;
          irq       <= 1'b1;
          state     <= SQ_RES;
        end
        SQ_RES: begin
          if (data_rd) irq <= 1'b0;
          if (ev_last) begin
            st1   <= '0;
            st2   <= '0;
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign cyl_o  = cyl_q;
  assign head_o = head_q;
  assign sec_o  = sec_q;
endmodule

// File: rtl/sector_seq_chk.sv
module sector_seq_chk #(
  parameter int CYL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_drop,
  input logic             res_start,
  input logic             irq,
  input logic             dio,
  input logic             mrq,
  input logic [7:0]       st0,
  input logic [7:0]       st1,
  input logic [7:0]       st2,
  input logic [CYL_W-1:0] cyl_o,
  input logic [CYL_W-1:0] max_cyl_q,
  input logic             head_o,
  input logic             ev_abort,
  input logic             ev_step,
  input logic             ev_extra
);
  // R5
  abort_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (st0[7:6] == 2'b01) && dma_drop);
  // R9
  drop_then_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_drop |=> res_start);
  // R9
  result_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_start |-> irq && dio);
  // R11
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dio) |-> (st1 == 8'h00) && (st2 == 8'h00) && mrq);
  // R3
  cyl_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && cyl_o <= max_cyl_q) |=> cyl_o <= max_cyl_q);
  // R7
  extra_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_extra |=> !st1[7] && (st0[2] == head_o));
  // R10
  dio_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dio |-> mrq);
endmodule

bind sector_seq sector_seq_chk #(.CYL_W(CYL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_drop(dma_drop), .res_start(res_start), .irq(irq),
  .dio(dio), .mrq(mrq), .st0(st0), .st1(st1), .st2(st2), .cyl_o(cyl_o),
  .max_cyl_q(max_cyl_q), .head_o(head_o), .ev_abort(ev_abort), .ev_step(ev_step),
  .ev_extra(ev_extra)
);

// File: tb/sector_seq_test.sv
`timescale 1ns/1ps
module sector_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_load = 0, mt_en = 0, start_head = 0, sector_done = 0, term_count = 0, data_rd = 0;
  logic [7:0] cmd_op = 0, spt = 0, max_cyl = 0, start_cyl = 0, start_sec = 0;
  logic [1:0] drv_sel = 0;
  logic [7:0] st0, st1, st2, cyl_o, sec_o, res_data;
  logic head_o, dma_drop, res_start, irq, mrq, dio;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sector_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_op(cmd_op), .drv_sel(drv_sel),
    .mt_en(mt_en), .spt(spt), .max_cyl(max_cyl), .start_cyl(start_cyl),
    .start_head(start_head), .start_sec(start_sec), .sector_done(sector_done),
    .term_count(term_count), .data_rd(data_rd), .st0(st0), .st1(st1), .st2(st2),
    .cyl_o(cyl_o), .head_o(head_o), .sec_o(sec_o), .dma_drop(dma_drop),
    .res_start(res_start), .irq(irq), .mrq(mrq), .dio(dio), .res_data(res_data)
  );

  typedef struct packed {
    logic [7:0] op; logic mt; logic [7:0] spt; logic [7:0] maxc; logic [7:0] c;
    logic h; logic [7:0] s; logic [1:0] n; logic tcl;
    logic [7:0] e0; logic [7:0] e1; logic [7:0] e3; logic [7:0] e4; logic [7:0] e5;
  } vec_t;

  // drive 1 throughout; tcl=1: term_count on the last pulse, tcl=0: never
  localparam vec_t VECS [10] = '{
    '{8'h46, 1'b0, 8'd18, 8'd79, 8'd3,  1'b0, 8'd5,  2'd2, 1'b1, 8'h01, 8'h00, 8'h03, 8'h00, 8'h07},
    '{8'h46, 1'b0, 8'd18, 8'd79, 8'd3,  1'b0, 8'd17, 2'd1, 1'b1, 8'h01, 8'h00, 8'h04, 8'h00, 8'h01},
    '{8'hE6, 1'b1, 8'd18, 8'd79, 8'd3,  1'b0, 8'd17, 2'd2, 1'b1, 8'h05, 8'h00, 8'h03, 8'h01, 8'h01},
    '{8'hC5, 1'b1, 8'd18, 8'd79, 8'd3,  1'b1, 8'd17, 2'd1, 1'b1, 8'h01, 8'h00, 8'h04, 8'h00, 8'h01},
    '{8'h45, 1'b0, 8'd18, 8'd79, 8'd3,  1'b0, 8'd17, 2'd2, 1'b0, 8'h41, 8'h80, 8'h03, 8'h00, 8'h12},
    '{8'h4A, 1'b0, 8'd18, 8'd79, 8'd3,  1'b0, 8'd17, 2'd1, 1'b1, 8'h01, 8'h80, 8'h03, 8'h00, 8'h12},
    '{8'h46, 1'b0, 8'd18, 8'd79, 8'd79, 1'b0, 8'd18, 2'd1, 1'b1, 8'h01, 8'h00, 8'h4F, 8'h00, 8'h01},
    '{8'h4D, 1'b1, 8'd18, 8'd79, 8'd10, 1'b0, 8'd18, 2'd1, 1'b1, 8'h05, 8'h00, 8'h0A, 8'h01, 8'h01},
    '{8'h66, 1'b1, 8'd18, 8'd79, 8'd3,  1'b1, 8'd17, 2'd2, 1'b0, 8'h45, 8'h80, 8'h03, 8'h01, 8'h12},
    '{8'hC6, 1'b1, 8'd9,  8'd79, 8'd79, 1'b1, 8'd9,  2'd1, 1'b1, 8'h01, 8'h00, 8'h4F, 8'h00, 8'h01}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 2: return "R2";
      1, 3: return "R7";
      4, 8: return "R5";
      5, 7: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic load_cmd(input logic [7:0] op, input logic [1:0] drv, input logic mt,
                          input logic [7:0] sp, input logic [7:0] mc, input logic [7:0] c,
                          input logic h, input logic [7:0] s);
    cmd_op = op; drv_sel = drv; mt_en = mt; spt = sp; max_cyl = mc;
    start_cyl = c; start_head = h; start_sec = s; cmd_load = 1'b1;
    @(negedge clk);
    cmd_load = 1'b0;
  endtask

  task automatic pulse(input logic tc);
    sector_done = 1'b1; term_count = tc;
    @(negedge clk);
    sector_done = 1'b0; term_count = 1'b0;
  endtask

  task automatic read_all(input string tag, input logic [6:0][7:0] ex);
    for (int i = 0; i < 7; i++) begin
      chk({tag, " R9 result byte"}, res_data, ex[i]);
      if (i == 6) chk("R10 dio before last read", {7'd0, dio}, 8'h01);
      data_rd = 1'b1;
      @(negedge clk);
      data_rd = 1'b0;
      if (i == 0) chk("R10 irq cleared by first read", {7'd0, irq}, 8'h00);
    end
    chk("R11 dio after last read", {7'd0, dio}, 8'h00);
    chk("R11 mrq after last read", {7'd0, mrq}, 8'h01);
    chk("R11 st1 cleared", st1, 8'h00);
    chk("R11 st2 cleared", st2, 8'h00);
  endtask

  task automatic finish_wait(input string tag);
    chk({tag, " R6 dma_drop"}, {7'd0, dma_drop}, 8'h01);
    chk({tag, " R9 res_start early"}, {7'd0, res_start}, 8'h00);
    @(negedge clk);
    chk({tag, " R9 res_start"}, {7'd0, res_start}, 8'h01);
    chk({tag, " R9 irq"}, {7'd0, irq}, 8'h01);
    chk({tag, " R10 dio"}, {7'd0, dio}, 8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 st0", st0, 8'h00);
    chk("R1 st1", st1, 8'h00);
    chk("R1 st2", st2, 8'h00);
    chk("R1 mrq", {7'd0, mrq}, 8'h01);
    chk("R1 dio/irq/pulses", {4'd0, dio, irq, res_start, dma_drop}, 8'h00);

    // R12 sector_done while idle is ignored
    pulse(1'b1);
    @(negedge clk);
    chk("R12 idle pulse res_start", {7'd0, res_start}, 8'h00);
    chk("R12 idle pulse st0", st0, 8'h00);
    chk("R12 idle pulse mrq", {7'd0, mrq}, 8'h01);

    for (int v = 0; v < 10; v++) begin
      load_cmd(VECS[v].op, 2'd1, VECS[v].mt, VECS[v].spt, VECS[v].maxc,
               VECS[v].c, VECS[v].h, VECS[v].s);
      chk({vec_tag(v), " busy mrq"}, {7'd0, mrq}, 8'h00);
      for (int p = 0; p < int'(VECS[v].n); p++) begin
        pulse((p == int'(VECS[v].n) - 1) ? VECS[v].tcl : 1'b0);
        if (!VECS[v].tcl && p == 0) chk("R4 eot flag set early", st1, 8'h80);
      end
      finish_wait(vec_tag(v));
      read_all(vec_tag(v), {8'h02, VECS[v].e5, VECS[v].e4, VECS[v].e3, 8'h00,
                            VECS[v].e1, VECS[v].e0});
      chk({vec_tag(v), " R11 st0 kept"}, st0, VECS[v].e0);
    end

    // R12 cmd_load while running is ignored; drive 2 lands in st0 bits 1:0 (R6)
    load_cmd(8'h46, 2'd2, 1'b0, 8'd18, 8'd79, 8'd3, 1'b0, 8'd5);
    load_cmd(8'h46, 2'd0, 1'b0, 8'd18, 8'd79, 8'd50, 1'b1, 8'd1);
    chk("R12 reload ignored cyl", cyl_o, 8'd3);
    pulse(1'b1);
    finish_wait("R12");
    read_all("R12", {8'h02, 8'h06, 8'h00, 8'h03, 8'h00, 8'h00, 8'h02});
    chk("R6 drive in st0", st0, 8'h02);

    summary();
  end
endmodule